// File: doc/BRIEF.md
# Streaming Packet Protocol Monitor

This block watches one valid/ready streaming link that carries packet delimiters, an empty count and a channel number. It never drives the link. It keeps its own record of which cycles the sink has made ready cycles, given a configurable ready latency, and its own record of whether a packet is open. Each kind of rule break sets a sticky flag of its own, and a one-cycle pulse shows that some rule broke on the cycle before.

The monitor goes on the link in simulation or in silicon as a debug aid. Its inputs are wired in parallel with the sink's inputs and the ready from the sink. `err_flags` holds every violation seen since the last reset. `viol_pulse` can trigger a capture. `pkt_open` shows the framing state that the monitor is tracking.

Top module: `stream_pkt_monitor`

## Requirements
- R1: A cycle is a ready cycle when `mon_ready` was high exactly READY_LAT cycles earlier. With READY_LAT = 0 it is the current `mon_ready`. Cycles whose earlier ready falls before the end of reset are not ready cycles.
- R2: `mon_valid` high on a cycle that is not a ready cycle sets `err_flags[0]`.
- R3: A beat is a ready cycle with `mon_valid` high. A beat with `mon_sop` high while a packet is open sets `err_flags[1]`.
- R4: A beat with `mon_eop` high, `mon_sop` low and no packet open sets `err_flags[2]`.
- R5: A beat with `mon_sop` and `mon_eop` both low and no packet open sets `err_flags[5]`.
- R6: A beat with `mon_eop` low and `mon_empty` nonzero sets `err_flags[3]`. Nonzero empty with `mon_eop` high is allowed.
- R7: A beat whose `mon_chan` is greater than MAX_CHAN sets `err_flags[4]`. A channel equal to MAX_CHAN is allowed.
- R8: On cycles that are not beats, `mon_sop`, `mon_eop`, `mon_empty` and `mon_chan` have no effect on `pkt_open` or on `err_flags[5:1]`.
- R9: A beat with `mon_sop` opens a packet and a beat with `mon_eop` closes it. A beat with both set leaves no packet open. `pkt_open` shows the new state from the clock edge that ends the beat.
- R10: Each flag is set at the clock edge that ends the violating cycle. It stays set until reset. Reset clears `err_flags`, `viol_pulse`, `pkt_open` and the ready history.
- R11: `viol_pulse` is high for the one cycle after any cycle that breaks a rule, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_ready | input | 1 | Ready driven by the sink |
| mon_valid | input | 1 | Valid driven by the source |
| mon_sop | input | 1 | Start-of-packet marker |
| mon_eop | input | 1 | End-of-packet marker |
| mon_empty | input | EMPTY_W | Count of unused symbols in the beat |
| mon_chan | input | CHAN_W | Channel number of the beat |
| err_flags | output | 6 | Sticky flags, one per violation type |
| viol_pulse | output | 1 | One-cycle pulse after a violating cycle |
| pkt_open | output | 1 | A packet is currently open |

## Verification
The assertions assume every monitored input is a known 0 or 1 from the first edge after reset. They also assume inputs change only away from the rising edge, so the ready history and the framing state see each beat exactly once. The bench drives every input on the falling edge and never leaves one undriven. It runs directed sequences that put each violation type on a fresh reset, so a sticky flag set earlier cannot hide a later one. It then runs long pseudo-random runs in which ready, valid, the delimiters, empty and channel change freely. These runs include stretches of invalid traffic on cycles that are not ready cycles.

// File: rtl/stream_pkt_monitor.sv
module stream_pkt_monitor #(
  parameter int READY_LAT = 2,
  parameter int EMPTY_W   = 2,
  parameter int CHAN_W    = 4,
  parameter int MAX_CHAN  = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mon_ready,
  input  logic               mon_valid,
  input  logic               mon_sop,
  input  logic               mon_eop,
  input  logic [EMPTY_W-1:0] mon_empty,
  input  logic [CHAN_W-1:0]  mon_chan,
  output logic [5:0]         err_flags,
  output logic               viol_pulse,
  output logic               pkt_open
);
  localparam int NFLAG = 6;

  logic             rdy_slot;
  logic             beat;
  logic [NFLAG-1:0] viol;

  generate
    if (READY_LAT == 0) begin : g_direct
      assign rdy_slot = mon_ready;
    end else begin : g_hist
      logic [READY_LAT-1:0] hist;
      always_ff @(posedge clk) begin
        if (!rst_n) hist <= '0;
        else        hist <= (hist << 1) | READY_LAT'(mon_ready);
      end
      assign rdy_slot = hist[READY_LAT-1];
    end
  endgenerate

  assign beat = rdy_slot & mon_valid;

  assign viol[0] = mon_valid & ~rdy_slot;
  assign viol[1] = beat & mon_sop & pkt_open;
  assign viol[2] = beat & mon_eop & ~mon_sop & ~pkt_open;
  assign viol[3] = beat & ~mon_eop & (mon_empty != '0);
  assign viol[4] = beat & (int'(mon_chan) > MAX_CHAN);
  assign viol[5] = beat & ~mon_sop & ~mon_eop & ~pkt_open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_flags  <= '0;
      viol_pulse <= 1'b0;
      pkt_open   <= 1'b0;
    end else begin
      err_flags  <= err_flags | viol;
      viol_pulse <= |viol;
      if (beat) pkt_open <= (mon_sop | pkt_open) & ~mon_eop;
    end
  end
endmodule

// File: rtl/stream_pkt_monitor_sva.sv
module stream_pkt_monitor_sva #(
  parameter int EMPTY_W  = 2,
  parameter int CHAN_W   = 4,
  parameter int MAX_CHAN = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rdy_slot,
  input logic               mon_valid,
  input logic               mon_sop,
  input logic               mon_eop,
  input logic [EMPTY_W-1:0] mon_empty,
  input logic [CHAN_W-1:0]  mon_chan,
  input logic [5:0]         err_flags,
  input logic               viol_pulse,
  input logic               pkt_open
);
  p_valid_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_valid && !rdy_slot) |=> (err_flags[0] && viol_pulse));

  p_chan_over_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_valid && rdy_slot && int'(mon_chan) > MAX_CHAN) |=> err_flags[4]);

  p_empty_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_valid && rdy_slot && !mon_eop && mon_empty != '0) |=> err_flags[3]);

  p_open_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mon_valid && rdy_slot) |=> $stable(pkt_open));

  p_sop_opens_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_valid && rdy_slot && mon_sop && !mon_eop) |=> pkt_open);

  p_eop_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_valid && rdy_slot && mon_eop) |=> !pkt_open);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  p_pulse_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> (err_flags != 6'd0));
endmodule

bind stream_pkt_monitor stream_pkt_monitor_sva #(
  .EMPTY_W(EMPTY_W), .CHAN_W(CHAN_W), .MAX_CHAN(MAX_CHAN)
) u_sva (
  .clk(clk), .rst_n(rst_n), .rdy_slot(rdy_slot), .mon_valid(mon_valid),
  .mon_sop(mon_sop), .mon_eop(mon_eop), .mon_empty(mon_empty),
  .mon_chan(mon_chan), .err_flags(err_flags), .viol_pulse(viol_pulse),
  .pkt_open(pkt_open)
);

// File: tb/stream_pkt_monitor_test.sv
`timescale 1ns/1ps
module stream_pkt_monitor_test;
  localparam int LAT = 2;
  localparam int EW  = 2;
  localparam int CW  = 4;
  localparam int MC  = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rdy = 1'b0, vld = 1'b0, sop = 1'b0, eop = 1'b0;
  logic [EW-1:0] emp = '0;
  logic [CW-1:0] chn = '0;
  logic [5:0] flags;
  logic pulse, popen;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int  hist[$];
  bit  m_open;
  bit [5:0] m_flags;
  bit  m_pulse;

  always #4 clk = ~clk;

  stream_pkt_monitor #(.READY_LAT(LAT), .EMPTY_W(EW), .CHAN_W(CW), .MAX_CHAN(MC)) uut (
    .clk(clk), .rst_n(rst_n), .mon_ready(rdy), .mon_valid(vld), .mon_sop(sop),
    .mon_eop(eop), .mon_empty(emp), .mon_chan(chn), .err_flags(flags),
    .viol_pulse(pulse), .pkt_open(popen));

  function automatic string flag_req(int i);
    case (i)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R6";
      4: return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic compare(string tag);
    for (int i = 0; i < 6; i++) begin
      checks++;
      if (flags[i] !== m_flags[i]) begin
        errors++;
        $display("FAIL %s/%s flag%0d actual=%b expected=%b", flag_req(i), tag, i, flags[i], m_flags[i]);
      end
    end
    checks++;
    if (pulse !== m_pulse) begin
      errors++;
      $display("FAIL R11/%s pulse actual=%b expected=%b", tag, pulse, m_pulse);
    end
    checks++;
    if (popen !== m_open) begin
      errors++;
      $display("FAIL R9/%s pkt_open actual=%b expected=%b", tag, popen, m_open);
    end
  endtask

  // R1 ready schedule, R8 non-beats ignored, R10 sticky: reference model
  task automatic model_step();
    bit rc, bt;
    bit [5:0] v;
    if (LAT == 0) rc = rdy;
    else rc = (hist.size() >= LAT) ? hist[hist.size()-LAT][0] : 1'b0;
    hist.push_back(int'(rdy));
    bt = rc && vld;
    v = '0;
    v[0] = vld && !rc;
    if (bt) begin
      v[1] = sop && m_open;
      v[2] = eop && !sop && !m_open;
      v[3] = !eop && (emp != 0);
      v[4] = int'(chn) > MC;
      v[5] = !sop && !eop && !m_open;
      if (sop) m_open = 1;
      if (eop) m_open = 0;
    end
    m_flags |= v;
    m_pulse = |v;
  endtask

  task automatic cyc(bit r, bit va, bit s, bit e, int em, int ch, string tag);
    @(negedge clk);
    rdy = r; vld = va; sop = s; eop = e; emp = EW'(em); chn = CW'(ch);
    @(posedge clk);
    model_step();
    #1 compare(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; rdy = 0; vld = 0; sop = 0; eop = 0; emp = '0; chn = '0;
    @(posedge clk);
    @(posedge clk);
    hist.delete(); m_open = 0; m_flags = '0; m_pulse = 0;
    #1 compare("R10 reset");
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic prime();
    cyc(1,0,0,0,0,0,"R1 prime");
    cyc(1,0,0,0,0,0,"R1 prime");
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: valid right after reset with ready high is not yet a ready cycle
    cyc(1,1,1,0,0,0,"R1 early");
    do_reset();
    prime();
    // R9: single-beat and multi-beat packets, empty on eop allowed (R6), chan==MAX (R7)
    cyc(1,1,1,1,3,MC,"R9 single");
    cyc(1,1,1,0,0,2,"R9 open");
    cyc(1,1,0,0,0,2,"R9 mid");
    cyc(1,1,0,1,2,2,"R9 close");
    // R8: garbage on non-beat cycles (valid low)
    cyc(1,0,0,1,3,15,"R8 idle");
    cyc(0,0,1,0,1,15,"R8 idle");
    cyc(0,0,0,1,2,14,"R8 idle");
    cyc(1,0,0,0,0,0,"R8 idle");
    // R2: valid on non-ready cycle (ready low two cycles ago)
    cyc(1,1,1,0,0,0,"R2 gap");
    cyc(1,0,0,0,0,0,"R2 after");
    do_reset(); prime();
    cyc(1,1,1,0,0,1,"R3 open");
    cyc(1,1,1,0,0,1,"R3 dup");
    cyc(1,1,0,1,0,1,"R3 close");
    do_reset(); prime();
    cyc(1,1,0,1,0,0,"R4 orphan");
    cyc(1,0,0,0,0,0,"R4 after");
    do_reset(); prime();
    cyc(1,1,0,0,0,0,"R5 stray");
    do_reset(); prime();
    cyc(1,1,1,0,1,0,"R6 empty");
    cyc(1,1,0,1,0,0,"R6 close");
    do_reset(); prime();
    cyc(1,1,1,1,0,MC+1,"R7 chan");
    cyc(1,0,0,0,0,0,"R10 sticky");
    cyc(1,0,0,0,0,0,"R10 sticky");
    // random runs with resets between
    for (int run = 0; run < 40; run++) begin
      do_reset();
      for (int k = 0; k < 300; k++) begin
        int u;
        u = $urandom;
        cyc(u[0] | u[1], u[2] & (u[3] | u[12]), u[4] & u[5], u[6] & u[7],
            (u[8] & u[9] & u[13]) ? int'(u[11:10]) : 0,
            (u[14] & u[15]) ? int'(u[19:16]) : int'(u[19:17]), "rand");
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule